// File: doc/BRIEF.md
# Configurable Interrupt Output Controller

This block gathers five interrupt causes into one interrupt pin: a periodic-timer expiry, an alarm match, a comparator crossing, a conversion-done strobe and a fan-fault strobe. Each cause sets a sticky status bit, and an enable register decides which pending bits may reach the pin. The comparator and fan causes share one status and enable position. Software clears a status bit by writing a one to it.

The pin is modelled as three outputs: a drive enable, a drive value and the direction of a weak pull. At rest the pin is left to the weak pull on its inactive level, so several pins can share one wire. The block drives the pin hard only to assert it. When the assert ends, the pin gets one cycle of hard inactive drive before the pull takes over again. Software picks one of four ways to use the pin: a level output, a fixed-length pulse output that fires again on every new cause, a square wave that inverts on each timer expiry, or a plain I/O pin. Software reaches the block through a small synchronous write port and a combinational read port.

Top module: `irq_pin_ctrl`

Register map (the address selects a register; the bit positions are the ones the block decodes):
- address 0, enable: bit 0 timer, bit 1 alarm, bit 2 comparator/fan, bit 3 conversion.
- address 1, status: the same bit positions. A read returns the pending bits, and writing a one clears that bit.
- address 2, config: bit 0 pulse mode (0 = level), bit 1 active-high (0 = active-low), bit 2 timer toggle mode, bit 3 I/O mode, bit 4 comparator falling edge (0 = rising), bit 5 I/O output value, bit 6 I/O drive enable.
- address 3, pin read: bit 0 is the pin input after the synchronizer (two flops by default).

## Requirements
- R1: After reset the enable, status and config registers read 0 and the pin is released (drive enable 0) with the weak pull high.
- R2: An event on a source sets its status bit (timer 0, alarm 1, comparator/fan 2, conversion 3) at the next clock edge, whether or not that source is enabled.
- R3: Writing address 1 clears each status bit whose data bit is 1 and leaves the others alone. If an event on a bit arrives in the same cycle as its clear, the bit stays set.
- R4: Config bit 4 chooses whether a rising (0) or a falling (1) crossing of the comparator input sets bit 2. A fan-fault strobe also sets bit 2.
- R5: In level mode the pin is hard-driven to the active level from the second clock edge after an enabled event, and it stays there while any enabled status bit is set.
- R6: When an active phase ends in level or pulse mode, the pin is hard-driven to the inactive level for exactly one cycle and is then released.
- R7: In pulse mode each event on an enabled source gives an active drive of exactly 4 cycles, starting at the second edge after the event, with no status clear needed.
- R8: One or more enabled events during a pulse queue exactly one further 4-cycle pulse, which follows the single inactive cycle.
- R9: Config bit 1 sets the active level. The weak pull always points at the inactive level.
- R10: In toggle mode the pin is always hard-driven. It starts at the inactive level and inverts one edge after each enabled timer event. Other sources do not move it.
- R11: In I/O mode the pin drive enable follows config bit 6 and the drive value follows config bit 5, whatever the interrupt state. The pin input is readable at address 3 bit 0.
- R12: Events on disabled sources do not drive the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| tmr_expire | input | 1 | Periodic-timer expiry strobe |
| alarm_hit | input | 1 | Alarm match strobe |
| cmp_level | input | 1 | Comparator output level |
| conv_done | input | 1 | Conversion complete strobe |
| fan_fault | input | 1 | Fan-fault strobe |
| pin_in | input | 1 | Sensed level on the pin |
| pin_oe | output | 1 | Hard-drive enable for the pin |
| pin_out | output | 1 | Hard-drive value for the pin |
| pin_pull_hi | output | 1 | Weak pull direction (1 = up, 0 = down) |

## Verification
A stuck or miscounted pulse counter shows up at the pins within a few cycles: an active run that is longer or shorter than four cycles, or a missing queued pulse after the one inactive cycle. A shaper that skips its inactive state shows as the drive enable dropping straight from the active level. A status flop that loses the race between event and clear shows one cycle later, both in the status read-back and as a level-mode pin that releases too early. A wrong toggle flop or comparator edge register shows in the pin value or the status read-back on the first event after the fault.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // status/enable bit positions (decoded by software)
   localparam int unsigned NPOS    = 4;
   localparam int unsigned POS_TMR = 0;
   localparam int unsigned POS_ALM = 1;
   localparam int unsigned POS_CMP = 2;
   localparam int unsigned POS_CNV = 3;

   // register addresses
   localparam int unsigned ADDR_EN  = 0;
   localparam int unsigned ADDR_ST  = 1;
   localparam int unsigned ADDR_CFG = 2;
   localparam int unsigned ADDR_PIN = 3;

   // configuration register, bit 0 at the bottom
   typedef struct packed {
      logic gpio_oe;    // bit 6
      logic gpio_val;   // bit 5
      logic cmp_fall;   // bit 4
      logic gpio_mode;  // bit 3
      logic toggle;     // bit 2
      logic act_high;   // bit 1
      logic pulse;      // bit 0
   } cfg_t;

   localparam int unsigned CFG_W = $bits(cfg_t);

   typedef enum logic [1:0] {
      SH_IDLE = 2'd0,
      SH_ACT  = 2'd1,
      SH_TAIL = 2'd2
   } shp_state_e;

endpackage

// File: rtl/irq_capture.sv
module irq_capture
   import irq_pkg::*;
#(
   parameter int unsigned NP = NPOS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tmr_expire,
   input  logic          alarm_hit,
   input  logic          cmp_level,
   input  logic          conv_done,
   input  logic          fan_fault,
   input  logic          cmp_fall,
   input  logic [NP-1:0] clr_vec,
   input  logic [NP-1:0] en_vec,
   output logic [NP-1:0] status,
   output logic          fresh,
   output logic          pending
);

   logic          cmp_prev;
   logic          cmp_edge;
   logic [NP-1:0] evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_prev <= 1'b0;
      else        cmp_prev <= cmp_level;
   end

   assign cmp_edge = cmp_fall ? (cmp_prev & ~cmp_level) : (~cmp_prev & cmp_level);

   always_comb begin
      evt          = '0;
      evt[POS_TMR] = tmr_expire;
      evt[POS_ALM] = alarm_hit;
      evt[POS_CMP] = cmp_edge | fan_fault;
      evt[POS_CNV] = conv_done;
   end

   // one sticky flop per position; an event beats a clear
   for (genvar i = 0; i < NP; i++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      status[i] <= 1'b0;
         else if (evt[i]) status[i] <= 1'b1;
         else if (clr_vec[i]) status[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fresh <= 1'b0;
      else        fresh <= |(evt & en_vec);
   end

   assign pending = |(status & en_vec);

endmodule

// File: rtl/irq_shaper.sv
module irq_shaper
   import irq_pkg::*;
#(
   parameter int unsigned PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic pulse_mode,
   input  logic pending,
   input  logic fresh,
   output logic drive,
   output logic active
);

   localparam int unsigned CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
   localparam logic [CW-1:0] LAST = CW'(PULSE_LEN - 1);

   shp_state_e    st_q, st_n;
   logic [CW-1:0] cnt_q, cnt_n;
   logic          queued_q, queued_n;
   logic          start;

   assign start = pulse_mode ? fresh : pending;

   always_comb begin
      st_n     = st_q;
      cnt_n    = cnt_q;
      queued_n = queued_q;
      case (st_q)
         SH_IDLE: begin
            if (start) begin
               st_n     = SH_ACT;
               cnt_n    = '0;
               queued_n = 1'b0;
            end
         end
         SH_ACT: begin
            if (pulse_mode) begin
               if (fresh) queued_n = 1'b1;
               if (cnt_q == LAST) st_n = SH_TAIL;
               else               cnt_n = cnt_q + CW'(1);
            end else if (!pending) begin
               st_n = SH_TAIL;
            end
         end
         SH_TAIL: begin
            if (pulse_mode ? (queued_q | fresh) : pending) begin
               st_n     = SH_ACT;
               cnt_n    = '0;
               queued_n = 1'b0;
            end else begin
               st_n = SH_IDLE;
            end
         end
         default: st_n = SH_IDLE;
      endcase
      if (!run) begin
         st_n     = SH_IDLE;
         cnt_n    = '0;
         queued_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SH_IDLE;
         cnt_q    <= '0;
         queued_q <= 1'b0;
      end else begin
         st_q     <= st_n;
         cnt_q    <= cnt_n;
         queued_q <= queued_n;
      end
   end

   assign drive  = (st_q != SH_IDLE);
   assign active = (st_q == SH_ACT);

endmodule

// File: rtl/irq_pin_mux.sv
module irq_pin_mux
   import irq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  cfg_t cfg,
   input  logic tmr_tick,
   input  logic shp_drive,
   input  logic shp_active,
   input  logic pin_in,
   output logic pin_oe,
   output logic pin_out,
   output logic pin_pull_hi,
   output logic pin_in_sync
);

   logic tog_q;
   logic act_lvl;

   assign act_lvl = cfg.act_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tog_q <= 1'b0;
      else if (!cfg.toggle) tog_q <= 1'b0;
      else if (tmr_tick)    tog_q <= ~tog_q;
   end

   always_comb begin
      if (cfg.gpio_mode) begin
         pin_oe  = cfg.gpio_oe;
         pin_out = cfg.gpio_val;
      end else if (cfg.toggle) begin
         pin_oe  = 1'b1;
         pin_out = tog_q ? act_lvl : ~act_lvl;
      end else begin
         pin_oe  = shp_drive;
         pin_out = shp_active ? act_lvl : ~act_lvl;
      end
   end

   assign pin_pull_hi = ~act_lvl;

   // input synchronizer: bypass or a chain of flops
   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_in_sync = pin_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_st
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sh[k] <= 1'b0;
               else        sh[k] <= sh[k-1];
            end
         end
      end
      assign pin_in_sync = sh[SYNC_STAGES-1];
   end

endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned AW          = 2,
   parameter int unsigned DW          = 8,
   parameter int unsigned PULSE_LEN   = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          tmr_expire,
   input  logic          alarm_hit,
   input  logic          cmp_level,
   input  logic          conv_done,
   input  logic          fan_fault,
   input  logic          pin_in,
   output logic          pin_oe,
   output logic          pin_out,
   output logic          pin_pull_hi
);

   if (AW < 2)         begin : g_bad_aw  $error("AW must be at least 2"); end
   if (DW < CFG_W)     begin : g_bad_dw  $error("DW must hold the config register"); end
   if (PULSE_LEN < 2)  begin : g_bad_pl  $error("PULSE_LEN must be at least 2"); end
   if (SYNC_STAGES > 4) begin : g_bad_ss $error("SYNC_STAGES must be 0 to 4"); end

   logic [NPOS-1:0] en_q;
   logic [NPOS-1:0] status_q;
   logic [NPOS-1:0] clr_vec;
   cfg_t            cfg_q;
   logic            fresh, pending, run;
   logic            shp_drive, shp_active, pin_in_sync;
   logic            unused_wr_hi;

   assign unused_wr_hi = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == AW'(ADDR_EN))  en_q  <= wr_data[NPOS-1:0];
         if (wr_addr == AW'(ADDR_CFG)) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
      end
   end

   assign clr_vec = (wr_en && wr_addr == AW'(ADDR_ST)) ? wr_data[NPOS-1:0] : '0;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         AW'(ADDR_EN):  rd_data[NPOS-1:0]  = en_q;
         AW'(ADDR_ST):  rd_data[NPOS-1:0]  = status_q;
         AW'(ADDR_CFG): rd_data[CFG_W-1:0] = cfg_q;
         AW'(ADDR_PIN): rd_data[0]         = pin_in_sync;
         default:       rd_data            = '0;
      endcase
   end

   irq_capture #(.NP(NPOS)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_expire (tmr_expire),
      .alarm_hit  (alarm_hit),
      .cmp_level  (cmp_level),
      .conv_done  (conv_done),
      .fan_fault  (fan_fault),
      .cmp_fall   (cfg_q.cmp_fall),
      .clr_vec    (clr_vec),
      .en_vec     (en_q),
      .status     (status_q),
      .fresh      (fresh),
      .pending    (pending)
   );

   assign run = !cfg_q.gpio_mode && !cfg_q.toggle;

   irq_shaper #(.PULSE_LEN(PULSE_LEN)) u_shp (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .pulse_mode (cfg_q.pulse),
      .pending    (pending),
      .fresh      (fresh),
      .drive      (shp_drive),
      .active     (shp_active)
   );

   irq_pin_mux #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg         (cfg_q),
      .tmr_tick    (tmr_expire & en_q[POS_TMR]),
      .shp_drive   (shp_drive),
      .shp_active  (shp_active),
      .pin_in      (pin_in),
      .pin_oe      (pin_oe),
      .pin_out     (pin_out),
      .pin_pull_hi (pin_pull_hi),
      .pin_in_sync (pin_in_sync)
   );

endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk
   import irq_pkg::*;
#(
   parameter int unsigned AW        = 2,
   parameter int unsigned DW        = 8,
   parameter int unsigned PULSE_LEN = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [DW-1:0]   wr_data,
   input logic            tmr_expire,
   input logic [NPOS-1:0] en_q,
   input logic [NPOS-1:0] status_q,
   input cfg_t            cfg_q,
   input logic            pin_oe,
   input logic            pin_out
);

   localparam int unsigned RW = $clog2(PULSE_LEN + 1) + 1;

   logic          run_m, lvl_m, pls_m, tg_m, act_now;
   cfg_t          cfg_prev;
   logic [RW-1:0] act_run;

   assign run_m   = !cfg_q.gpio_mode && !cfg_q.toggle;
   assign lvl_m   = run_m && !cfg_q.pulse;
   assign pls_m   = run_m && cfg_q.pulse;
   assign tg_m    = cfg_q.toggle && !cfg_q.gpio_mode;
   assign act_now = pin_oe && (pin_out == cfg_q.act_high);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_prev <= '0;
         act_run  <= '0;
      end else begin
         cfg_prev <= cfg_q;
         if (pls_m && cfg_q == cfg_prev && act_now) begin
            if (act_run != '1) act_run <= act_run + RW'(1);
         end else begin
            act_run <= '0;
         end
      end
   end

   // R3: write-one clears the timer bit when no event competes
   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(ADDR_ST) && wr_data[POS_TMR] && !tmr_expire) |=> !status_q[POS_TMR]);

   // R3: an event beats a same-cycle clear
   p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expire |=> status_q[POS_TMR]);

   // R5: level mode holds the active level while anything enabled is pending
   p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_m && act_now && |(status_q & en_q)) |=>
      ((cfg_q != $past(cfg_q)) || (pin_oe && pin_out == cfg_q.act_high)));

   // R6: release only after a cycle of hard inactive drive
   p_tail_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_m && cfg_q == $past(cfg_q) && $fell(pin_oe)) |->
      ($past(pin_out) != cfg_q.act_high));

   // R7: an unbroken active run in pulse mode never exceeds PULSE_LEN
   p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      act_run <= RW'(PULSE_LEN));

   // R10: toggle mode inverts the pin after an enabled timer event
   p_toggle_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_m && $past(tg_m) && $past(tmr_expire && en_q[POS_TMR])) |->
      (pin_oe && pin_out != $past(pin_out)));

endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(
   .AW(AW), .DW(DW), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .tmr_expire (tmr_expire),
   .en_q       (en_q),
   .status_q   (status_q),
   .cfg_q      (cfg_q),
   .pin_oe     (pin_oe),
   .pin_out    (pin_out)
);

// File: tb/irq_pin_ctrl_tb.sv
module irq_pin_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       tmr_expire = 1'b0, alarm_hit = 1'b0, cmp_level = 1'b0;
   logic       conv_done = 1'b0, fan_fault = 1'b0, pin_in = 1'b0;
   logic       pin_oe, pin_out, pin_pull_hi;

   int   n_chk = 0;
   int   n_bad = 0;
   logic cur_act = 1'b0;

   always #5 clk = ~clk;

   irq_pin_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tmr_expire(tmr_expire), .alarm_hit(alarm_hit),
      .cmp_level(cmp_level), .conv_done(conv_done), .fan_fault(fan_fault), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pull_hi(pin_pull_hi)
   );

   // status walk: {tmr,alarm,cmp,conv,fan}, write-clear flag, clear mask, expected status
   localparam int NV = 10;
   localparam logic [13:0] VEC [NV] = '{
      {5'b10000, 1'b0, 4'h0, 4'h1},
      {5'b01000, 1'b0, 4'h0, 4'h3},
      {5'b00010, 1'b0, 4'h0, 4'hB},
      {5'b00000, 1'b1, 4'h1, 4'hA},
      {5'b00100, 1'b0, 4'h0, 4'hE},
      {5'b00100, 1'b1, 4'h4, 4'hA},
      {5'b00000, 1'b0, 4'h0, 4'hA},
      {5'b00001, 1'b0, 4'h0, 4'hE},
      {5'b10000, 1'b1, 4'hF, 4'h1},
      {5'b00000, 1'b1, 4'h1, 4'h0}
   };

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %0h exp %0h", tag, got, exp);
      end
   endtask

   // 0 released, 1 hard inactive, 2 hard active
   function automatic logic [1:0] pin_code();
      if (!pin_oe) return 2'd0;
      return (pin_out == cur_act) ? 2'd2 : 2'd1;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic expect_seq(input logic [23:0] codes, input string tag);
      for (int k = 0; k < 12; k++) begin
         check(tag, {30'd0, pin_code()}, {30'd0, codes[23-2*k -: 2]});
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R1..R12 got hang exp finish");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      @(negedge clk);
      do_reset();

      // R1 reset state
      check("R1 oe", pin_oe, 0);
      check("R1 pull", pin_pull_hi, 1);
      rd(0, d); check("R1 enable", d, 0);
      rd(1, d); check("R1 status", d, 0);
      rd(2, d); check("R1 config", d, 0);

      // R2 R3 R4 status walk
      for (int i = 0; i < NV; i++) begin
         {tmr_expire, alarm_hit, cmp_level, conv_done, fan_fault} = VEC[i][13:9];
         wr_en = VEC[i][8]; wr_addr = 2'd1; wr_data = {4'h0, VEC[i][7:4]};
         @(negedge clk);
         {tmr_expire, alarm_hit, conv_done, fan_fault} = '0;
         wr_en = 1'b0; wr_data = '0;
         rd(1, d);
         check($sformatf("R2 R3 R4 vector %0d", i), d, {4'h0, VEC[i][3:0]});
      end
      cmp_level = 1'b0;

      // R4 falling-edge selection
      do_reset();
      wr_reg(2, 8'h10);
      cmp_level = 1'b1; @(negedge clk);
      rd(1, d); check("R4 rise ignored when falling selected", d[2], 0);
      cmp_level = 1'b0; @(negedge clk);
      rd(1, d); check("R4 falling crossing", d[2], 1);

      // R12 disabled source
      do_reset();
      alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check("R12 disabled leaves pin released", pin_oe, 0);
         @(negedge clk);
      end
      rd(1, d); check("R2 status without enable", d[1], 1);

      // R5 R6 R9 level mode, active low
      do_reset();
      cur_act = 1'b0;
      wr_reg(0, 8'h0F);
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      check("R5 not before second edge", pin_code(), 0);
      @(negedge clk);
      check("R5 asserted", pin_code(), 2);
      check("R9 active low value", pin_out, 0);
      repeat (3) @(negedge clk);
      check("R5 held while pending", pin_code(), 2);
      wr_reg(1, 8'h01);
      check("R5 held one edge after clear", pin_code(), 2);
      @(negedge clk);
      check("R6 hard inactive phase", pin_code(), 1);
      @(negedge clk);
      check("R6 released", pin_code(), 0);

      // R7 R9 pulse mode, active high
      do_reset();
      wr_reg(0, 8'h0F);
      wr_reg(2, 8'h03);
      cur_act = 1'b1;
      check("R9 pull toward low", pin_pull_hi, 0);
      conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
      expect_seq(24'h2A9000, "R7 pulse");
      conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
      expect_seq(24'h2A9000, "R7 repeat without clear");

      // R8 queued pulse
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      fork
         expect_seq(24'h2A9AA4, "R8 queued pulse");
         begin
            repeat (2) @(negedge clk);
            alarm_hit = 1'b1; @(negedge clk);
            alarm_hit = 1'b0; conv_done = 1'b1; @(negedge clk);
            conv_done = 1'b0;
         end
      join

      // R10 toggle mode, active low
      do_reset();
      cur_act = 1'b0;
      wr_reg(0, 8'h01);
      wr_reg(2, 8'h04);
      check("R10 driven inactive at start", {pin_oe, pin_out}, 2'b11);
      alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0;
      check("R10 other source no effect", {pin_oe, pin_out}, 2'b11);
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      check("R10 first flip", {pin_oe, pin_out}, 2'b10);
      @(negedge clk);
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      check("R10 second flip", {pin_oe, pin_out}, 2'b11);

      // R11 I/O mode
      do_reset();
      wr_reg(0, 8'h0F);
      wr_reg(2, 8'h68);
      check("R11 drive high", {pin_oe, pin_out}, 2'b11);
      wr_reg(2, 8'h48);
      check("R11 drive low", {pin_oe, pin_out}, 2'b10);
      wr_reg(2, 8'h08);
      tmr_expire = 1'b1; @(negedge clk); tmr_expire = 1'b0;
      repeat (2) @(negedge clk);
      check("R11 released despite pending", pin_oe, 0);
      pin_in = 1'b1; repeat (3) @(negedge clk);
      rd(3, d); check("R11 input high", d[0], 1);
      pin_in = 1'b0; repeat (3) @(negedge clk);
      rd(3, d); check("R11 input low", d[0], 0);

      summary();
      $finish;
   end

endmodule